// File: doc/BRIEF.md
# Outbound Command Packet Register Front End

This block sits behind a crate-style backplane register port. It lets a host assemble a variable-length command packet for a remote network device, one register access at a time. The host first loads a destination word, which names the remote node and the service access point, and a function word. It then streams 16-bit data words. Each write to the address-pointer register opens a new segment by placing a delimiter entry in the outbound buffer, so one packet can carry several address/data runs.

A read of the execute register closes the packet. The block latches the externally supplied error status, and the buffered packet leaves on a valid/ready stream: the destination word, then the function word, then the buffered entries in write order. The same read clears the per-device valid bit of the target node. That bit stays clear until an update for the node is reported on the update input. Every register read carries the current error status in its upper bits.

Top module: `cmd_pkt_front`

## Requirements
- R1: After reset, all registers and the error status read as zero, `pkt_valid_o` is low and every bit of `dev_valid_o` is 0.
- R2: The destination (address 0), function (address 1) and pointer (address 2) registers read back in `rdata_o[15:0]`. Each changes only on an accepted write to its own address or on reset, and does not auto-increment.
- R3: `rdata_o[24:17]` always shows the current 8-bit error status and `rdata_o[16]` is 0. Reads of address 3 (data) and address 4 (execute) return 0 in `rdata_o[15:0]`.
- R4: A write to address 3 appends a buffer entry with tag bit 16 = 0 and the written word in bits 15:0.
- R5: A write to address 2 updates the pointer register and appends a delimiter entry with tag bit 16 = 1 and the pointer value in bits 15:0.
- R6: An idle read of address 4 emits on the stream the destination word, then the function word (both with tag 0), then the buffered entries in write order. `pkt_last_o` is high on the final word only. The error status takes the value of `ext_status_i`.
- R7: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_valid_o`, `pkt_data_o` and `pkt_last_o` hold their values.
- R8: A data or pointer write while the buffer holds DEPTH entries is dropped: no entry is added, the pointer register is unchanged, and the error status becomes 0xE1.
- R9: While a packet is still draining, any write and any execute read is dropped, and the error status becomes 0xE2.
- R10: An accepted execute clears `dev_valid_o[n]`, where n is the low DEV_W bits of destination bits 15:8. `upd_valid_i` sets `dev_valid_o[upd_dev_i]`. When both target the same bit in one cycle, the clear wins.
- R11: After a packet has drained the buffer is empty, so the next execute with no new writes emits only the two header words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Register access strobe, one access per cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address: 0 destination, 1 function, 2 pointer, 3 data, 4 execute |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 25 | Read data: [24:17] status, [16] zero, [15:0] register |
| ext_status_i | input | 8 | Status byte latched on execute |
| pkt_valid_o | output | 1 | Stream word valid |
| pkt_ready_i | input | 1 | Stream consumer ready |
| pkt_data_o | output | 17 | Stream word: [16] delimiter tag, [15:0] value |
| pkt_last_o | output | 1 | Final word of the packet |
| upd_valid_i | input | 1 | Update packet arrived for a device |
| upd_dev_i | input | 4 | Device index of the update |
| dev_valid_o | output | 16 | Per-device valid bits |

## Verification
The assertions check on every cycle that the stream holds steady under backpressure, that the register-held fields move only on their own writes, that the buffer never exceeds its depth and takes no entries while draining, that the drop paths load the right status codes, and that a clear beats a same-cycle set. Only the bench scenarios can show the complete packet contents and order, the segment delimiters that pointer writes place between data runs, the drop of a full-buffer write as seen through later reads, and the header-only packet after a drain.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int DW = 16;
  localparam int EW = DW + 1;
  localparam logic [2:0] A_DEST = 3'd0;
  localparam logic [2:0] A_FUNC = 3'd1;
  localparam logic [2:0] A_PTR  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_EXEC = 3'd4;
  localparam logic [7:0] ST_OVF  = 8'hE1;
  localparam logic [7:0] ST_BUSY = 8'hE2;
  typedef enum logic [1:0] {S_IDLE, S_DST, S_FN, S_BODY} drain_e;
endpackage

// File: rtl/cpf_regs.sv
module cpf_regs
  import cpf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dest_we_i,
  input  logic          func_we_i,
  input  logic          ptr_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          stat_ld_i,
  input  logic [7:0]    stat_val_i,
  output logic [DW-1:0] dest_o,
  output logic [DW-1:0] func_o,
  output logic [DW-1:0] ptr_o,
  output logic [7:0]    stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_o <= '0;
      func_o <= '0;
      ptr_o  <= '0;
      stat_o <= '0;
    end else begin
      if (dest_we_i) dest_o <= wdata_i;
      if (func_we_i) func_o <= wdata_i;
      if (ptr_we_i)  ptr_o  <= wdata_i;
      if (stat_ld_i) stat_o <= stat_val_i;
    end
  end

  // R2
  dest_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dest_we_i |=> $stable(dest_o));
  // R2
  func_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !func_we_i |=> $stable(func_o));
  // R2
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ptr_we_i |=> $stable(ptr_o));
endmodule

// File: rtl/cpf_pktbuf.sv
module cpf_pktbuf
  import cpf_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [EW-1:0] push_data_i,
  input  logic          start_i,
  input  logic [DW-1:0] dest_i,
  input  logic [DW-1:0] func_i,
  output logic          busy_o,
  output logic          full_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [EW-1:0] data_o,
  output logic          last_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] rd_q;
  logic [DW-1:0] hdst_q, hfn_q;
  drain_e        st_q;
  logic          fire;

  assign busy_o  = (st_q != S_IDLE);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = busy_o;
  assign fire    = valid_o && ready_i;

  always_comb begin
    data_o = '0;
    last_o = 1'b0;
    case (st_q)
      S_DST:  data_o = {1'b0, hdst_q};
      S_FN: begin
        data_o = {1'b0, hfn_q};
        last_o = (cnt_q == '0);
      end
      S_BODY: begin
        data_o = mem_q[rd_q];
        last_o = ((CW'(rd_q) + CW'(1)) == cnt_q);
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (push_i && !busy_o && cnt_q == CW'(g)) mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      rd_q   <= '0;
      hdst_q <= '0;
      hfn_q  <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (push_i && !full_o) cnt_q <= cnt_q + CW'(1);
          if (start_i) begin
            st_q   <= S_DST;
            hdst_q <= dest_i;
            hfn_q  <= func_i;
          end
        end
        S_DST: if (fire) st_q <= S_FN;
        S_FN: if (fire) begin
          rd_q <= '0;
          st_q <= (cnt_q == '0) ? S_IDLE : S_BODY;
        end
        S_BODY: if (fire) begin
          if (last_o) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
            rd_q  <= '0;
          end else begin
            rd_q <= rd_q + IW'(1);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R7
  stream_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(last_o)));
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R9
  no_push_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !push_i);
  // R11
  empty_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/cpf_devvalid.sv
module cpf_devvalid #(
  parameter int NDEV = 16,
  localparam int XW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [XW-1:0]   clr_idx_i,
  input  logic            set_i,
  input  logic [XW-1:0]   set_idx_i,
  output logic [NDEV-1:0] valid_o
);
  for (genvar g = 0; g < NDEV; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) valid_o[g] <= 1'b0;
      else if (clr_i && clr_idx_i == XW'(g)) valid_o[g] <= 1'b0;
      else if (set_i && set_idx_i == XW'(g)) valid_o[g] <= 1'b1;
    end
  end

  // R10
  clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !valid_o[$past(clr_idx_i)]);
  // R10
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !(clr_i && clr_idx_i == set_idx_i)) |=> valid_o[$past(set_idx_i)]);
endmodule

// File: rtl/cmd_pkt_front.sv
module cmd_pkt_front
  import cpf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NDEV  = 16,
  localparam int XW   = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cyc_i,
  input  logic            wr_i,
  input  logic [2:0]      addr_i,
  input  logic [15:0]     wdata_i,
  output logic [24:0]     rdata_o,
  input  logic [7:0]      ext_status_i,
  output logic            pkt_valid_o,
  input  logic            pkt_ready_i,
  output logic [16:0]     pkt_data_o,
  output logic            pkt_last_o,
  input  logic            upd_valid_i,
  input  logic [XW-1:0]   upd_dev_i,
  output logic [NDEV-1:0] dev_valid_o
);
  logic [DW-1:0] dest_q, func_q, ptr_q;
  logic [7:0]    stat_q, stat_val;
  logic          busy, full;
  logic          wr_acc, rd_acc, buf_wr, wr_busy_drop, full_drop;
  logic          exec_go, exec_drop, stat_ld, push;

  assign wr_acc       = cyc_i && wr_i;
  assign rd_acc       = cyc_i && !wr_i;
  assign buf_wr       = wr_acc && (addr_i == A_DATA || addr_i == A_PTR);
  assign wr_busy_drop = wr_acc && busy;
  assign full_drop    = buf_wr && !busy && full;
  assign push         = buf_wr && !busy && !full;
  assign exec_go      = rd_acc && addr_i == A_EXEC && !busy;
  assign exec_drop    = rd_acc && addr_i == A_EXEC && busy;
  assign stat_ld      = exec_go || exec_drop || wr_busy_drop || full_drop;
  assign stat_val     = exec_go ? ext_status_i : (full_drop ? ST_OVF : ST_BUSY);

  cpf_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dest_we_i  (wr_acc && !busy && addr_i == A_DEST),
    .func_we_i  (wr_acc && !busy && addr_i == A_FUNC),
    .ptr_we_i   (push && addr_i == A_PTR),
    .wdata_i    (wdata_i),
    .stat_ld_i  (stat_ld),
    .stat_val_i (stat_val),
    .dest_o     (dest_q),
    .func_o     (func_q),
    .ptr_o      (ptr_q),
    .stat_o     (stat_q)
  );

  cpf_pktbuf #(.DEPTH(DEPTH)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({addr_i == A_PTR, wdata_i}),
    .start_i     (exec_go),
    .dest_i      (dest_q),
    .func_i      (func_q),
    .busy_o      (busy),
    .full_o      (full),
    .valid_o     (pkt_valid_o),
    .ready_i     (pkt_ready_i),
    .data_o      (pkt_data_o),
    .last_o      (pkt_last_o)
  );

  cpf_devvalid #(.NDEV(NDEV)) u_valid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (exec_go),
    .clr_idx_i (dest_q[8 +: XW]),
    .set_i     (upd_valid_i),
    .set_idx_i (upd_dev_i),
    .valid_o   (dev_valid_o)
  );

  logic [DW-1:0] sel;
  always_comb begin
    case (addr_i)
      A_DEST:  sel = dest_q;
      A_FUNC:  sel = func_q;
      A_PTR:   sel = ptr_q;
      default: sel = '0;
    endcase
  end
  assign rdata_o = {stat_q, 1'b0, sel};

  // R8
  ovf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_drop |=> (rdata_o[24:17] == ST_OVF));
  // R9
  busy_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_drop || wr_busy_drop) |=> (rdata_o[24:17] == ST_BUSY));
  // R6
  exec_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_go |=> (pkt_valid_o && pkt_data_o == {1'b0, $past(dest_q)}));
endmodule

// File: tb/sim_cmd_pkt_front.sv
module sim_cmd_pkt_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [24:0] rdata;
  logic [7:0]  ext_st = '0;
  logic        pv, pr = 1'b1, pl;
  logic [16:0] pd;
  logic        uv = 1'b0;
  logic [3:0]  ud = '0;
  logic [15:0] dv;
  int          n_tests = 0, n_fail = 0;
  logic [16:0] got [32];
  int          n_got;
  logic [24:0] r;

  always #5 clk = ~clk;

  cmd_pkt_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ext_status_i(ext_st),
    .pkt_valid_o(pv), .pkt_ready_i(pr), .pkt_data_o(pd), .pkt_last_o(pl),
    .upd_valid_i(uv), .upd_dev_i(ud), .dev_valid_o(dv)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [15:0] d, output logic [24:0] rd);
    @(negedge clk);
    cyc = 1'b1; wr = w; addr = a; wdata = d;
    #1 rd = rdata;
    @(posedge clk);
    #1 cyc = 1'b0; wr = 1'b0;
  endtask

  task automatic collect();
    n_got = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pv) begin
        got[n_got] = pd;
        n_got++;
        if (pl) break;
      end
    end
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk(rdata == '0, "R1 rdata", 32'(rdata), 0);
    chk(!pv, "R1 valid", 32'(pv), 0);
    chk(dv == '0, "R1 dev_valid", 32'(dv), 0);
  endtask

  task automatic t_basic();
    logic [16:0] exp [7];
    exp = '{17'h00305, 17'h000A7, 17'h10040, 17'h01111, 17'h02222, 17'h10100, 17'h03333};
    @(negedge clk); uv = 1'b1; ud = 4'd3;
    @(negedge clk); uv = 1'b0;
    chk(dv[3], "R10 set", 32'(dv), 32'h8);
    acc(1, 3'd0, 16'h0305, r);
    acc(1, 3'd1, 16'h00A7, r);
    acc(1, 3'd2, 16'h0040, r);
    acc(1, 3'd3, 16'h1111, r);
    acc(1, 3'd3, 16'h2222, r);
    acc(1, 3'd2, 16'h0100, r);
    acc(1, 3'd3, 16'h3333, r);
    acc(0, 3'd0, 16'h0, r);
    chk(r[15:0] == 16'h0305, "R2 dest readback", 32'(r), 32'h0305);
    acc(0, 3'd2, 16'h0, r);
    chk(r[15:0] == 16'h0100, "R2 ptr readback", 32'(r), 32'h0100);
    acc(0, 3'd3, 16'h0, r);
    chk(r[15:0] == 16'h0, "R3 data reads zero", 32'(r), 0);
    ext_st = 8'h5A;
    acc(0, 3'd4, 16'h0, r);
    collect();
    chk(n_got == 7, "R6 length", 32'(n_got), 7);
    for (int i = 0; i < 7; i++)
      chk(got[i] == exp[i], "R4 R5 R6 word", 32'(got[i]), 32'(exp[i]));
    chk(!dv[3], "R10 clear on exec", 32'(dv), 0);
    acc(0, 3'd1, 16'h0, r);
    chk(r == {8'h5A, 1'b0, 16'h00A7}, "R3 status bits", 32'(r), 32'h00B400A7);
    acc(0, 3'd0, 16'h0, r);
    chk(r[15:0] == 16'h0305, "R2 dest unchanged", 32'(r), 32'h0305);
  endtask

  task automatic t_header_only();
    ext_st = 8'h11;
    acc(0, 3'd4, 16'h0, r);
    collect();
    chk(n_got == 2, "R11 header only", 32'(n_got), 2);
    chk(got[1] == 17'h000A7, "R11 func last", 32'(got[1]), 32'hA7);
  endtask

  task automatic t_backpressure();
    pr = 1'b0;
    acc(1, 3'd0, 16'h0707, r);
    acc(1, 3'd3, 16'hBEEF, r);
    acc(0, 3'd4, 16'h0, r);
    @(negedge clk);
    chk(pv && pd == 17'h00707, "R7 first word", 32'(pd), 32'h0707);
    @(negedge clk); @(negedge clk);
    chk(pv && pd == 17'h00707, "R7 hold", 32'(pd), 32'h0707);
    acc(1, 3'd0, 16'h9999, r);
    acc(0, 3'd0, 16'h0, r);
    chk(r[15:0] == 16'h0707, "R9 write dropped", 32'(r), 32'h0707);
    chk(r[24:17] == 8'hE2, "R9 busy code", 32'(r[24:17]), 32'hE2);
    ext_st = 8'h33;
    acc(0, 3'd4, 16'h0, r);
    acc(0, 3'd1, 16'h0, r);
    chk(r[24:17] == 8'hE2, "R9 exec dropped", 32'(r[24:17]), 32'hE2);
    pr = 1'b1;
    collect();
    chk(n_got == 3 && got[2] == 17'h0BEEF, "R9 packet intact", 32'(n_got), 3);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 8; i++) acc(1, 3'd3, 16'(i + 16'h100), r);
    acc(1, 3'd3, 16'hDEAD, r);
    acc(0, 3'd1, 16'h0, r);
    chk(r[24:17] == 8'hE1, "R8 ovf code", 32'(r[24:17]), 32'hE1);
    acc(1, 3'd2, 16'h4444, r);
    acc(0, 3'd2, 16'h0, r);
    chk(r[15:0] == 16'h0100, "R8 ptr unchanged", 32'(r), 32'h0100);
    ext_st = 8'h00;
    acc(0, 3'd4, 16'h0, r);
    collect();
    chk(n_got == 10, "R8 length", 32'(n_got), 10);
    chk(got[9] == 17'h00107, "R8 last kept", 32'(got[9]), 32'h107);
    acc(0, 3'd0, 16'h0, r);
    chk(r[24:17] == 8'h00, "R6 status loaded", 32'(r[24:17]), 0);
  endtask

  task automatic t_clr_prio();
    acc(1, 3'd0, 16'h0501, r);
    @(negedge clk); uv = 1'b1; ud = 4'd5;
    @(negedge clk); uv = 1'b0;
    chk(dv[5], "R10 set 5", 32'(dv), 32'h20);
    @(negedge clk);
    cyc = 1'b1; wr = 1'b0; addr = 3'd4; uv = 1'b1; ud = 4'd5;
    @(posedge clk);
    #1 cyc = 1'b0; uv = 1'b0;
    collect();
    chk(!dv[5], "R10 clear wins", 32'(dv), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_basic();
    t_header_only();
    t_backpressure();
    t_overflow();
    t_clr_prio();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule